// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block forms the NaN result of a two-input floating-point operation in which at least one operand is a NaN. Each operand is sorted into one of three classes: ordinary value, quiet NaN or signaling NaN. One operand is then chosen under one of four priority policies picked at run time. A chosen signaling NaN is turned into a quiet NaN on the way out. An invalid-operation flag is raised whenever a signaling NaN is present. Arithmetic on ordinary values is left to the surrounding datapath, which calls on this block only once it has found a NaN input.

The operand width is a parameter. At 32 bits the word is 1 sign bit, 8 exponent bits and 23 fraction bits. At 64 bits it is 1 sign bit, 11 exponent bits and 52 fraction bits. Two run-time inputs set how signaling NaNs are recognised and whether every NaN result is replaced by one fixed default NaN. A request is taken when its valid strobe is high. The result and the flag appear together in the next cycle, with their own valid strobe.

Top module: `nan_prop_sel`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. With `sig_msb_high`=0, a NaN whose fraction MSB is 0 is signaling and one whose MSB is 1 is quiet. With `sig_msb_high`=1 the meaning of the MSB is reversed.
- R2: `invalid` is 1 exactly when at least one operand is a signaling NaN, and this holds even when `dflt_mode` replaces the result.
- R3: The default NaN has sign 0 and an all-ones exponent. With `sig_msb_high`=0 its fraction has only the MSB set; with `sig_msb_high`=1 its fraction has every bit set except the MSB. When `dflt_mode`=1 the result is always the default NaN.
- R4: Policy code 0 selects a if a is signaling, else b if b is signaling, else a if a is a quiet NaN, else b.
- R5: Policy code 1 selects a if a is any NaN, and b otherwise.
- R6: Policy code 2 with `use_first`=1 selects a if a is a NaN, else b. With `use_first`=0 it selects b if b is a NaN, else a.
- R7: Policy code 3 works as follows. When one operand is signaling and the other is quiet, it selects the quiet one. When both are NaNs of the same class, it selects the one with the larger significand. When only one operand is a NaN, it selects that NaN.
- R8: For the larger-significand choice, both words are compared with the sign bit removed. When those magnitudes are equal, a counts as larger only if its full word is below b's, that is, a is positive and b is negative.
- R9: A selected signaling NaN is quieted. With `sig_msb_high`=0 its fraction MSB is set and all other bits are kept. With `sig_msb_high`=1 it is replaced by the default NaN. A selected quiet NaN passes through unchanged.
- R10: `result`, `invalid` and `out_valid` are updated on the clock edge that samples `in_valid`=1, so they appear one cycle later, and `out_valid` is high for that one cycle only. After a cycle with `in_valid`=0, `out_valid` is 0 and `result` and `invalid` hold their values.
- R11: After a synchronous reset, `out_valid`, `result` and `invalid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| policy | input | 2 | Priority policy code, 0 to 3 |
| use_first | input | 1 | Direction bit for policy 2 |
| dflt_mode | input | 1 | Force the default NaN as result |
| sig_msb_high | input | 1 | 1: fraction MSB set marks a signaling NaN |
| out_valid | output | 1 | Result strobe |
| result | output | WIDTH | Selected, quieted NaN |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The hardest case to reach is the last tie-break under policy 3. It needs two NaNs of the same class whose words are identical except for the sign. Random fractions almost never produce such a pair. The stimulus builds these pairs directly, in both sign orders and under both polarities. Random pairs drawn from classes chosen at random, with a random direction bit and random modes, then cover the other combinations of policy and class.

// File: rtl/nanp_pkg.sv
// Shared types for the NaN result selector.
// Assumes every user imports the package; carries no logic of its own.
package nanp_pkg;

    // Operand class produced by the classifier.
    typedef enum logic [1:0] {
        CLS_NUM   = 2'd0,
        CLS_QUIET = 2'd1,
        CLS_SIG   = 2'd2
    } nan_cls_e;

    // Run-time priority policy codes.
    typedef enum logic [1:0] {
        POL_SIG_FIRST = 2'd0,
        POL_A_ANY     = 2'd1,
        POL_STEERED   = 2'd2,
        POL_MAGNITUDE = 2'd3
    } pick_pol_e;

    // Exponent width belonging to a word width (binary32 or binary64 layout).
    function automatic int exp_width(input int w);
        return (w == 64) ? 11 : 8;
    endfunction

endpackage

// File: rtl/nanp_classify.sv
// Sorts one operand into ordinary value, quiet NaN or signaling NaN.
// Assumes the usual sign / exponent / fraction layout, with the fraction MSB
// as the quiet/signal discriminator whose meaning is set by sig_msb_high.
module nanp_classify
    import nanp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word,
    input  logic             sig_msb_high,
    output nan_cls_e         cls
);
    localparam int EXP_W  = exp_width(WIDTH);
    localparam int FRAC_W = WIDTH - 1 - EXP_W;

    logic exp_full;
    logic frac_nz;
    logic disc_bit;

    // Field decode.
    always_comb begin
        exp_full = &word[WIDTH-2 -: EXP_W];
        frac_nz  = |word[FRAC_W-1:0];
        disc_bit = word[FRAC_W-1];
    end

    // Class from field decode and polarity.
    always_comb begin
        if (!(exp_full && frac_nz))
            cls = CLS_NUM;
        else if (disc_bit == sig_msb_high)
            cls = CLS_SIG;
        else
            cls = CLS_QUIET;
    end
endmodule

// File: rtl/nanp_pick.sv
// Chooses which operand supplies the NaN result under one of four policies.
// Assumes at least one operand is a NaN; pick_b = 1 selects operand b.
module nanp_pick
    import nanp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_word,
    input  logic [WIDTH-1:0] b_word,
    input  nan_cls_e         a_cls,
    input  nan_cls_e         b_cls,
    input  logic [1:0]       policy,
    input  logic             use_first,
    output logic             pick_b
);
    logic a_nan, b_nan, a_sig, b_sig, a_qt, b_qt;
    logic a_larger;

    // Class shorthands.
    always_comb begin
        a_sig = (a_cls == CLS_SIG);
        b_sig = (b_cls == CLS_SIG);
        a_qt  = (a_cls == CLS_QUIET);
        b_qt  = (b_cls == CLS_QUIET);
        a_nan = a_sig || a_qt;
        b_nan = b_sig || b_qt;
    end

    // Magnitude compare with the sign dropped; sign decides an exact tie.
    always_comb begin
        if (a_word[WIDTH-2:0] != b_word[WIDTH-2:0])
            a_larger = (a_word[WIDTH-2:0] > b_word[WIDTH-2:0]);
        else
            a_larger = (a_word < b_word);
    end

    // Policy decision.
    always_comb begin
        case (pick_pol_e'(policy))
            POL_SIG_FIRST: begin
                if (a_sig)      pick_b = 1'b0;
                else if (b_sig) pick_b = 1'b1;
                else if (a_qt)  pick_b = 1'b0;
                else            pick_b = 1'b1;
            end
            POL_A_ANY:     pick_b = !a_nan;
            POL_STEERED:   pick_b = use_first ? !a_nan : b_nan;
            POL_MAGNITUDE: begin
                if (a_sig)
                    pick_b = b_sig ? !a_larger : b_qt;
                else if (a_qt)
                    pick_b = b_qt ? !a_larger : 1'b0;
                else
                    pick_b = 1'b1;
            end
            default:       pick_b = 1'b1;
        endcase
    end
endmodule

// File: rtl/nan_prop_sel.sv
// Two-operand NaN result selector: classify, choose, quiet, register.
// Assumes at least one operand of an accepted request is a NaN; results for
// two ordinary operands are not meaningful. One-cycle latency, no stalls.
module nan_prop_sel
    import nanp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [1:0]       policy,
    input  logic             use_first,
    input  logic             dflt_mode,
    input  logic             sig_msb_high,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             invalid
);
    localparam int EXP_W  = exp_width(WIDTH);
    localparam int FRAC_W = WIDTH - 1 - EXP_W;
    localparam logic [WIDTH-1:0] DN_STD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [WIDTH-1:0] DN_INV =
        {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
    localparam logic [WIDTH-1:0] QUIET_BIT =
        {{(EXP_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [WIDTH-1:0] ops [2];
    nan_cls_e         cls [2];
    logic             pick_b;
    logic [WIDTH-1:0] chosen;
    nan_cls_e         chosen_cls;
    logic [WIDTH-1:0] dnan;
    logic [WIDTH-1:0] next_result;
    logic             next_invalid;

    // Operand array for the classifier instances.
    always_comb begin
        ops[0] = op_a;
        ops[1] = op_b;
    end

    // One classifier per operand.
    for (genvar i = 0; i < 2; i++) begin : g_cls
        nanp_classify #(.WIDTH(WIDTH)) u_cls (
            .word         (ops[i]),
            .sig_msb_high (sig_msb_high),
            .cls          (cls[i])
        );
    end

    nanp_pick #(.WIDTH(WIDTH)) u_pick (
        .a_word    (op_a),
        .b_word    (op_b),
        .a_cls     (cls[0]),
        .b_cls     (cls[1]),
        .policy    (policy),
        .use_first (use_first),
        .pick_b    (pick_b)
    );

    // Selected operand, default NaN, quieting and flag.
    always_comb begin
        chosen       = pick_b ? op_b : op_a;
        chosen_cls   = pick_b ? cls[1] : cls[0];
        dnan         = sig_msb_high ? DN_INV : DN_STD;
        next_invalid = (cls[0] == CLS_SIG) || (cls[1] == CLS_SIG);
        if (dflt_mode)
            next_result = dnan;
        else if (chosen_cls == CLS_SIG)
            next_result = sig_msb_high ? dnan : (chosen | QUIET_BIT);
        else
            next_result = chosen;
    end

    // Output register; result and flag only load on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            invalid   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= next_result;
                invalid <= next_invalid;
            end
        end
    end

    // R10: a strobe in gives a strobe out one cycle later, and only then.
    p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(invalid)));

    // R2: a signaling operand always leads to the flag.
    p_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cls[0] == CLS_SIG || cls[1] == CLS_SIG)) |=> invalid);

    // R3: default mode forces the default NaN of the sampled polarity.
    p_dflt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dflt_mode) |=>
        (result == ($past(sig_msb_high) ? DN_INV : DN_STD)));

    // R9: with a NaN present the result is a NaN with the quiet encoding.
    p_out_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cls[0] != CLS_NUM || cls[1] != CLS_NUM)) |=>
        ((&result[WIDTH-2 -: EXP_W]) && (|result[FRAC_W-1:0]) &&
         (result[FRAC_W-1] != $past(sig_msb_high))));

    // R5: policy 1 passes a quiet a through untouched.
    p_first_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dflt_mode && policy == 2'd1 && cls[0] == CLS_QUIET)
        |=> (result == $past(op_a)));

    // R6: policy 2 steered to b passes a quiet b through untouched.
    p_steer_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dflt_mode && policy == 2'd2 && !use_first &&
         cls[1] == CLS_QUIET) |=> (result == $past(op_b)));
endmodule

// File: tb/tb_nan_prop_sel.sv
// Scoreboard bench: the driver queues expected items, the monitor compares.
module tb_nan_prop_sel;
    localparam int W = 32;

    typedef struct {
        logic [31:0] res;
        logic        inv;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [1:0]  policy = '0;
    logic        use_first = 1'b0, dflt_mode = 1'b0, sig_msb_high = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        invalid;

    int checks = 0;
    int fails  = 0;
    bit mon_on = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    nan_prop_sel #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .policy(policy), .use_first(use_first), .dflt_mode(dflt_mode),
        .sig_msb_high(sig_msb_high), .out_valid(out_valid), .result(result),
        .invalid(invalid)
    );

    // Reference model, written from the requirements.
    // Class: 0 value, 1 quiet, 2 signaling (R1).
    function automatic int m_cls(logic [31:0] x, logic sp);
        if (x[30:23] != 8'hFF || x[22:0] == 23'd0) return 0;
        return (x[22] == sp) ? 2 : 1;
    endfunction

    function automatic logic [31:0] m_dn(logic sp);  // R3
        return sp ? 32'h7FBF_FFFF : 32'h7FC0_0000;
    endfunction

    function automatic bit m_a_big(logic [31:0] a, logic [31:0] b);  // R8
        if (a[30:0] > b[30:0]) return 1'b1;
        if (a[30:0] < b[30:0]) return 1'b0;
        return (a[31] == 1'b0 && b[31] == 1'b1);
    endfunction

    function automatic bit m_take_b(logic [31:0] a, logic [31:0] b, int ca, int cb,
                                    logic [1:0] p, logic uf);
        case (p)
            2'd0: begin  // R4
                if (ca == 2) return 1'b0;
                if (cb == 2) return 1'b1;
                return (ca != 1);
            end
            2'd1: return (ca == 0);                     // R5
            2'd2: return uf ? (ca == 0) : (cb != 0);    // R6
            default: begin                              // R7
                if (ca != 0 && cb != 0 && ca == cb) return !m_a_big(a, b);
                if (ca == 2 && cb == 1) return 1'b1;
                if (ca == 1 && cb == 2) return 1'b0;
                return (ca == 0);
            end
        endcase
    endfunction

    // Drive one request on a falling edge and queue its expectation.
    task automatic send(logic [31:0] a, logic [31:0] b, logic [1:0] p, logic uf,
                        logic dm, logic sp, string tag);
        exp_t e;
        int ca, cb;
        logic [31:0] pick;
        ca = m_cls(a, sp);
        cb = m_cls(b, sp);
        pick = m_take_b(a, b, ca, cb, p, uf) ? b : a;
        if (dm) e.res = m_dn(sp);
        else if (m_cls(pick, sp) == 2) e.res = sp ? m_dn(sp) : (pick | 32'h0040_0000);  // R9
        else e.res = pick;
        e.inv = (ca == 2) || (cb == 2);  // R2
        e.tag = tag;
        @(negedge clk);
        op_a = a; op_b = b; policy = p; use_first = uf; dflt_mode = dm;
        sig_msb_high = sp; in_valid = 1'b1;
        sb.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Monitor: compare each output strobe with the head of the scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_on && out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10 unexpected strobe", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(result == e.res, {e.tag, " result"}, result, e.res);
                    check(invalid == e.inv, {e.tag, " invalid"},
                          {31'd0, invalid}, {31'd0, e.inv});
                end
            end
        end
    end

    // Random operand of a given class (0 value, 1 quiet, 2 signaling).
    function automatic logic [31:0] mk(int c, logic sp);
        logic [31:0] x;
        x = $urandom;
        if (c == 0) begin
            x[30:23] = 8'h7F ^ 8'($urandom_range(0, 60));
            return x;
        end
        x[30:23] = 8'hFF;
        x[22] = (c == 2) ? sp : !sp;
        if (x[21:0] == 22'd0) x[0] = 1'b1;
        return x;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    localparam logic [31:0] QN = 32'h7FC0_0001;  // quiet under polarity 0
    localparam logic [31:0] SN = 32'h7F80_0005;  // signaling under polarity 0
    localparam logic [31:0] NUM = 32'h3F80_0000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state.
        check(out_valid == 1'b0 && result == 32'd0 && invalid == 1'b0,
              "R11 reset state", result, 32'd0);
        mon_on = 1'b1;

        // R4 policy 0.
        send(QN, SN, 2'd0, 0, 0, 0, "R4 sig b over quiet a");
        send(SN, SN | 32'h10, 2'd0, 0, 0, 0, "R4 sig a first");
        send(QN, 32'hFFC0_0002, 2'd0, 0, 0, 0, "R4 quiet a first");
        send(NUM, QN, 2'd0, 0, 0, 0, "R4 b only");
        // R5 policy 1.
        send(QN, SN, 2'd1, 0, 0, 0, "R5 a any nan");
        send(NUM, SN, 2'd1, 0, 0, 0, "R5 b fallback");
        // R6 policy 2.
        send(SN, QN, 2'd2, 1, 0, 0, "R6 first set");
        send(SN, QN, 2'd2, 0, 0, 0, "R6 first clear");
        send(QN, NUM, 2'd2, 0, 0, 0, "R6 b not nan");
        // R7 / R8 policy 3.
        send(SN, QN, 2'd3, 0, 0, 0, "R7 sig a vs quiet b");
        send(QN, SN, 2'd3, 0, 0, 0, "R7 quiet a vs sig b");
        send(32'h7FC0_0010, 32'h7FC0_0020, 2'd3, 0, 0, 0, "R7 two quiet larger b");
        send(32'h7F80_0030, 32'h7F80_0020, 2'd3, 0, 0, 0, "R7 two sig larger a");
        send(NUM, SN, 2'd3, 0, 0, 0, "R7 single nan");
        send(32'h7FC0_0007, 32'hFFC0_0007, 2'd3, 0, 0, 0, "R8 tie a positive");
        send(32'hFFC0_0007, 32'h7FC0_0007, 2'd3, 0, 0, 0, "R8 tie a negative");
        send(32'h7F80_0009, 32'hFF80_0009, 2'd3, 0, 0, 0, "R8 sig tie");
        send(32'hFFA0_0000, 32'h7FA0_0000, 2'd3, 0, 0, 1, "R8 tie inverted");
        // R1 polarity flips the class of the same word.
        send(QN, SN, 2'd0, 0, 0, 1, "R1 inverted polarity");
        send(32'h7F80_0000, QN, 2'd1, 0, 0, 0, "R1 infinity is not nan");
        // R9 quieting.
        send(32'hFF80_1234, NUM, 2'd1, 0, 0, 0, "R9 quiet by msb");
        send(32'h7FC1_2345, NUM, 2'd1, 0, 0, 1, "R9 inverted gives default");
        // R3 / R2 default mode.
        send(SN, QN, 2'd0, 0, 1, 0, "R3 default std");
        send(QN, NUM, 2'd0, 0, 1, 1, "R3 default inverted");
        send(NUM, QN, 2'd3, 0, 1, 0, "R2 no flag in default mode");

        // R10: idle cycle keeps result and drops the strobe.
        send(32'h7FC0_ABCD, NUM, 2'd1, 0, 0, 0, "R10 load");
        op_a = SN; op_b = SN; dflt_mode = 1'b1;
        @(posedge clk);
        #2;
        check(out_valid == 1'b0 && result == 32'h7FC0_ABCD, "R10 hold when idle",
              result, 32'h7FC0_ABCD);
        dflt_mode = 1'b0;

        // Random classes, modes and policies.
        for (int i = 0; i < 400; i++) begin
            int ca, cb;
            logic sp;
            logic [31:0] a, b;
            sp = 1'($urandom);
            ca = $urandom_range(0, 2);
            cb = (ca == 0) ? $urandom_range(1, 2) : $urandom_range(0, 2);
            a = mk(ca, sp);
            b = mk(cb, sp);
            if ($urandom_range(0, 7) == 0 && ca != 0) begin
                b = a;
                b[31] = ~a[31];
            end
            send(a, b, 2'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0), sp,
                 "R7 random mix");
        end

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R10 all results returned", sb.size(), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule